// File: doc/BRIEF.md
# Frame-Size-Adaptive Data Queue

This block is a first-in first-out queue for serial data frames of up to 32 bits. Its storage always holds 32 words, but the number of entries it accepts depends on configuration. In normal mode only four entries are used. In large mode the usable depth follows the programmed frame width: narrow frames get the whole array and wide frames get a quarter of it. A configuration strobe loads the mode bit and the frame width together. A width the block cannot handle is refused, and the previously stored width is kept.

A controller uses two copies of the block. The transmit copy (`KIND = Q_TX`) silently discards writes once it is full. The receive copy (`KIND = Q_RX`) also discards them, and it raises a sticky overflow flag that stays set until the next read. Writes and reads are single-cycle strobes. Read data appears one cycle after the read strobe, marked by `rd_valid`. A synchronous flush empties the queue. The outputs report the current level, the active depth, and empty, almost-full, full and overflow flags.

Top module: `adaptive_frame_fifo`

## Requirements
- R1: After reset: `level` = 0, `depth` = 4, `empty` = 1, `almost_full` = 0, `full` = 0, `overflow` = 0, `rd_valid` = 0, `pop_data` = 0.
- R2: `depth` is 4 when the mode bit is 0. When the mode bit is 1, `depth` is 32 for a stored width of 0..8, 16 for 9..16, and 8 for 17..32. A configuration write takes effect on the next clock edge.
- R3: A configuration write with `cfg_size` above 32 leaves the stored width unchanged but still loads `cfg_big`.
- R4: Data leaves in the order it was accepted. A `pop_valid` in cycle n, without `flush`, gives `rd_valid` = 1 and the data on `pop_data` in cycle n+1. `pop_data` holds its value until the next such read.
- R5: `almost_full` is 1 exactly when `level` equals `depth` − 1. `full` is 1 exactly when `level` ≥ `depth`.
- R6: In the transmit variant, a push while `level` ≥ `depth` (and no pop that frees an entry) is dropped: `level` is unchanged, the data never appears, and `overflow` stays 0.
- R7: In the receive variant, such a refused push sets `overflow` to 1 and its data is discarded.
- R8: Any `pop_valid` without `flush` clears `overflow`. `empty` becomes 1 when the last entry leaves.
- R9: A pop while empty returns `pop_data` = 0 with `rd_valid` = 1, and leaves `level` and the stored order unchanged.
- R10: `flush` sets `level` to 0 and `empty` to 1, and clears `full` and `overflow`. A push or pop in the same cycle is ignored, and `rd_valid` is 0 in the next cycle.
- R11: A push and a pop in the same cycle at `level` = `depth` are both accepted, and `level` stays at `depth`.
- R12: `level` always equals the number of entries accepted and not yet read, and never exceeds 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_big | input | 1 | Large-queue mode bit |
| cfg_size | input | 6 | Frame width in bits |
| flush | input | 1 | Synchronous empty command |
| push_valid | input | 1 | Write strobe |
| push_data | input | 32 | Write data |
| pop_valid | input | 1 | Read strobe |
| pop_data | output | 32 | Read data, one cycle after the read strobe |
| rd_valid | output | 1 | Marks the cycle after a read strobe |
| level | output | 6 | Current occupancy |
| depth | output | 6 | Active usable depth |
| empty | output | 1 | Occupancy is zero |
| almost_full | output | 1 | Occupancy equals depth minus one |
| full | output | 1 | Occupancy is at or above depth |
| overflow | output | 1 | Sticky refused-push flag (receive variant) |

## Verification
Several functions can act in the same clock cycle. A read and a write can arrive together when the queue sits exactly at its depth. A refused write can coincide with a read that would clear the overflow flag. A flush can coincide with a read or a write. A configuration change can land while the queue is fuller than the new depth. Directed sequences force each of these combinations. Random traffic with occasional reconfiguration and flushes then revisits them many times. After every cycle, a bench model decides which operations were accepted, and the level, flags, depth and read data are compared against it.

// File: rtl/aff_pkg.sv
package aff_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic {Q_TX = 1'b0, Q_RX = 1'b1} queue_kind_e;

  // Usable depth from the mode bit and the stored frame width.
  function automatic int unsigned eff_depth(input logic big, input int unsigned width,
                                            input int unsigned max_d, input int unsigned small_d);
    if (!big)             return small_d;
    else if (width <= 8)  return max_d;
    else if (width <= 16) return max_d / 2;
    else                  return max_d / 4;
  endfunction
endpackage

// File: rtl/aff_depth_cfg.sv
module aff_depth_cfg #(
  parameter int SIZE_W      = 6,
  parameter int CNT_W       = 6,
  parameter int MAX_DEPTH   = 32,
  parameter int SMALL_DEPTH = 4,
  parameter int MAX_FRAME   = 32,
  parameter int RESET_SIZE  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_big,
  input  logic [SIZE_W-1:0] cfg_size,
  output logic [CNT_W-1:0]  depth_q,
  output logic [CNT_W-1:0]  depth_d
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [SIZE_W:0] FRAME_LIM = (SIZE_W+1)'(MAX_FRAME);

  logic [SIZE_W-1:0] size_q, size_d;
  logic              big_q, big_d;

  always_comb begin
    size_d = size_q;
    big_d  = big_q;
    if (cfg_we) begin
      big_d = cfg_big;
      if ({1'b0, cfg_size} <= FRAME_LIM) size_d = cfg_size;
    end
    depth_d = CNT_W'(aff_pkg::eff_depth(big_d, 32'(size_d), MAX_DEPTH, SMALL_DEPTH));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q  <= SIZE_W'(RESET_SIZE);
      big_q   <= 1'b0;
      depth_q <= CNT_W'(SMALL_DEPTH);
    end else begin
      size_q  <= size_d;
      big_q   <= big_d;
      depth_q <= depth_d;
    end
  end

  // R3: an out-of-range width leaves the stored width alone
  p_size_reject_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && ({1'b0, cfg_size} > FRAME_LIM)) |=> (size_q == $past(size_q)));

  // R2: the active depth is one of the legal sizes
  p_depth_legal_r2: assert property (@(posedge clk) disable iff (rst)
    ($countones(depth_q) == 1) && (depth_q >= CNT_W'(SMALL_DEPTH)));
endmodule

// File: rtl/aff_store.sv
module aff_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_hit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              zero_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_q <= mem[rd_addr];
  end

  // A read of an empty queue is masked to zero.
  always_ff @(posedge clk) begin
    if (rst)        zero_q <= 1'b1;
    else if (rd_en) zero_q <= ~rd_hit;
  end

  assign rd_data = zero_q ? '0 : rd_q;

  // R9: an empty read yields zero
  p_zero_on_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_hit) |=> (rd_data == '0));
endmodule

// File: rtl/aff_occupancy.sv
module aff_occupancy #(
  parameter int                  CNT_W     = 6,
  parameter int                  ADDR_W    = 5,
  parameter int                  MAX_DEPTH = 32,
  parameter aff_pkg::queue_kind_e KIND     = aff_pkg::Q_RX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [CNT_W-1:0]  depth_q,
  input  logic [CNT_W-1:0]  depth_d,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic              pop_ok,
  output logic [CNT_W-1:0]  level,
  output logic              empty,
  output logic              almost_full,
  output logic              full,
  output logic              overflow
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] wp_q, rp_q;
  logic              push_ok, reject;

  always_comb begin
    pop_ok  = pop & ~flush & (cnt_q != '0);
    push_ok = push & ~flush & ((cnt_q < depth_q) | (pop_ok & (cnt_q == depth_q)));
    reject  = push & ~flush & ~push_ok;
    if (flush) cnt_d = '0;
    else       cnt_d = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      wp_q        <= '0;
      rp_q        <= '0;
      empty       <= 1'b1;
      full        <= 1'b0;
      almost_full <= 1'b0;
    end else begin
      cnt_q       <= cnt_d;
      empty       <= (cnt_d == '0);
      full        <= (cnt_d >= depth_d);
      almost_full <= (cnt_d == depth_d - CNT_W'(1));
      if (flush) begin
        wp_q <= '0;
        rp_q <= '0;
      end else begin
        if (push_ok) wp_q <= wp_q + ADDR_W'(1);
        if (pop_ok)  rp_q <= rp_q + ADDR_W'(1);
      end
    end
  end

  assign wr_en  = push_ok;
  assign wr_ptr = wp_q;
  assign rd_ptr = rp_q;
  assign level  = cnt_q;

  generate
    if (KIND == aff_pkg::Q_RX) begin : g_rx_flag
      logic ovf_q;
      always_ff @(posedge clk) begin
        if (rst)         ovf_q <= 1'b0;
        else if (flush)  ovf_q <= 1'b0;
        else if (reject) ovf_q <= 1'b1;
        else if (pop)    ovf_q <= 1'b0;
      end
      assign overflow = ovf_q;

      // R7: a refused receive push raises the flag
      p_ovf_set_r7: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> overflow);
      // R8: a read with no refused push clears it
      p_ovf_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !flush) |=> !overflow);
    end else begin : g_tx_flag
      assign overflow = 1'b0;
    end
  endgenerate

  // R6: a push into a full queue leaves the level alone
  p_drop_full_r6: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> (level == $past(level)));
  // R10: flush empties the queue
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (empty && (level == '0) && !full));
  // R9: an empty read without a write keeps the queue empty
  p_empty_pop_r9: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push && !flush) |=> empty);
  // R12: occupancy never exceeds the storage
  p_level_bound_r12: assert property (@(posedge clk) disable iff (rst)
    level <= CNT_W'(MAX_DEPTH));
endmodule

// File: rtl/adaptive_frame_fifo.sv
module adaptive_frame_fifo #(
  parameter int                   DATA_W      = 32,
  parameter int                   MAX_DEPTH   = 32,
  parameter int                   SMALL_DEPTH = 4,
  parameter int                   SIZE_W      = 6,
  parameter int                   MAX_FRAME   = 32,
  parameter aff_pkg::queue_kind_e KIND        = aff_pkg::Q_RX,
  parameter int                   CNT_W       = $clog2(MAX_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_big,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic              flush,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  output logic              rd_valid,
  output logic [CNT_W-1:0]  level,
  output logic [CNT_W-1:0]  depth,
  output logic              empty,
  output logic              almost_full,
  output logic              full,
  output logic              overflow
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int ADDR_W = $clog2(MAX_DEPTH);

  logic [CNT_W-1:0]  depth_q, depth_d;
  logic              wr_en, pop_ok, rd_en;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;

  aff_depth_cfg #(
    .SIZE_W(SIZE_W), .CNT_W(CNT_W), .MAX_DEPTH(MAX_DEPTH),
    .SMALL_DEPTH(SMALL_DEPTH), .MAX_FRAME(MAX_FRAME), .RESET_SIZE(SMALL_DEPTH)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_big(cfg_big), .cfg_size(cfg_size),
    .depth_q(depth_q), .depth_d(depth_d)
  );

  aff_occupancy #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .MAX_DEPTH(MAX_DEPTH), .KIND(KIND)
  ) u_occ (
    .clk(clk), .rst(rst), .push(push_valid), .pop(pop_valid), .flush(flush),
    .depth_q(depth_q), .depth_d(depth_d), .wr_en(wr_en), .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr), .pop_ok(pop_ok), .level(level), .empty(empty),
    .almost_full(almost_full), .full(full), .overflow(overflow)
  );

  assign rd_en = pop_valid & ~flush;

  aff_store #(
    .DATA_W(DATA_W), .DEPTH(MAX_DEPTH), .ADDR_W(ADDR_W)
  ) u_mem (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_ptr), .wr_data(push_data),
    .rd_en(rd_en), .rd_hit(pop_ok), .rd_addr(rd_ptr), .rd_data(pop_data)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_en;
  end

  assign depth = depth_q;

  // R4: every read strobe is answered in the next cycle
  p_rd_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    (pop_valid && !flush) |=> rd_valid);
  // R5: full and almost-full are never both set
  p_flags_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(full && almost_full));
endmodule

// File: tb/sim_adaptive_frame_fifo.sv
module sim_adaptive_frame_fifo;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_big = 1'b0, flush = 1'b0;
  logic [5:0]  cfg_size = '0;
  logic        push_valid = 1'b0, pop_valid = 1'b0;
  logic [31:0] push_data = '0;
  logic [31:0] rx_data, tx_data;
  logic        rx_rv, tx_rv, rx_empty, tx_empty, rx_af, tx_af, rx_full, tx_full, rx_ovf, tx_ovf;
  logic [5:0]  rx_level, tx_level, rx_depth, tx_depth;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mq [$];
  int          m_depth = 4;
  int          m_size = 4;
  bit          m_big = 0;
  bit          m_ovf = 0;
  bit          exp_rv = 0;
  logic [31:0] exp_data = '0;

  always #2.5 clk = ~clk;

  adaptive_frame_fifo #(.KIND(aff_pkg::Q_RX)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_big(cfg_big), .cfg_size(cfg_size),
    .flush(flush), .push_valid(push_valid), .push_data(push_data), .pop_valid(pop_valid),
    .pop_data(rx_data), .rd_valid(rx_rv), .level(rx_level), .depth(rx_depth),
    .empty(rx_empty), .almost_full(rx_af), .full(rx_full), .overflow(rx_ovf));

  adaptive_frame_fifo #(.KIND(aff_pkg::Q_TX)) u1 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_big(cfg_big), .cfg_size(cfg_size),
    .flush(flush), .push_valid(push_valid), .push_data(push_data), .pop_valid(pop_valid),
    .pop_data(tx_data), .rd_valid(tx_rv), .level(tx_level), .depth(tx_depth),
    .empty(tx_empty), .almost_full(tx_af), .full(tx_full), .overflow(tx_ovf));

  function automatic int calc_depth(bit big, int width);
    if (!big) return 4;
    if (width <= 8) return 32;
    if (width <= 16) return 16;
    return 8;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int n = mq.size();
    chk("R12", "rx level", 32'(rx_level), 32'(n));
    chk("R12", "tx level", 32'(tx_level), 32'(n));
    chk("R2", "depth", 32'(rx_depth), 32'(m_depth));
    chk("R2", "tx depth", 32'(tx_depth), 32'(m_depth));
    chk("R8", "empty", 32'(rx_empty), 32'(n == 0));
    chk("R8", "tx empty", 32'(tx_empty), 32'(n == 0));
    chk("R5", "full", 32'(rx_full), 32'(n >= m_depth));
    chk("R5", "tx full", 32'(tx_full), 32'(n >= m_depth));
    chk("R5", "almost_full", 32'(rx_af), 32'(n == m_depth - 1));
    chk("R7", "rx overflow", 32'(rx_ovf), 32'(m_ovf));
    chk("R6", "tx overflow", 32'(tx_ovf), 32'd0);
    chk("R4", "rd_valid", 32'(rx_rv), 32'(exp_rv));
    chk("R4", "tx rd_valid", 32'(tx_rv), 32'(exp_rv));
    if (exp_rv) begin
      chk("R4", "rx pop_data", rx_data, exp_data);
      chk("R4", "tx pop_data", tx_data, exp_data);
    end
  endtask

  // One clock: drive at the falling edge, model, compare at the next falling edge.
  task automatic cyc(input bit ps, input logic [31:0] d, input bit pp, input bit fl,
                     input bit we, input bit big, input int width);
    int  n = mq.size();
    bit  pop_ok = pp && !fl && (n > 0);
    bit  push_ok = ps && !fl && ((n < m_depth) || (pop_ok && n == m_depth));
    push_valid = ps; push_data = d; pop_valid = pp; flush = fl;
    cfg_we = we; cfg_big = big; cfg_size = 6'(width);
    if (fl) begin
      mq.delete();
      m_ovf = 0;
      exp_rv = 0;
    end else begin
      exp_rv = pp;
      if (pp) exp_data = pop_ok ? mq.pop_front() : 32'd0;
      if (push_ok) mq.push_back(d);
      if (ps && !push_ok) m_ovf = 1;
      else if (pp) m_ovf = 0;
    end
    if (we) begin
      m_big = big;
      if (width <= 32) m_size = width;
      m_depth = calc_depth(m_big, m_size);
    end
    @(posedge clk);
    @(negedge clk);
    push_valid = 0; pop_valid = 0; flush = 0; cfg_we = 0;
    compare_all();
  endtask

  task automatic push1(input logic [31:0] d); cyc(1, d, 0, 0, 0, 0, 0); endtask
  task automatic pop1(); cyc(0, 0, 1, 0, 0, 0, 0); endtask
  task automatic cfg1(input bit big, input int width); cyc(0, 0, 0, 0, 1, big, width); endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "level", 32'(rx_level), 0);
    chk("R1", "depth", 32'(rx_depth), 4);
    chk("R1", "empty", 32'(rx_empty), 1);
    chk("R1", "full", 32'(rx_full), 0);
    chk("R1", "almost_full", 32'(rx_af), 0);
    chk("R1", "overflow", 32'(rx_ovf), 0);
    chk("R1", "rd_valid", 32'(rx_rv), 0);
    chk("R1", "pop_data", rx_data, 0);

    // R5, R6, R7: fill the small queue and push one more
    for (int i = 0; i < 5; i++) push1(32'hA000 + 32'(i));
    chk("R7", "rx overflow after refused push", 32'(rx_ovf), 1);
    chk("R6", "tx drop keeps level", 32'(tx_level), 4);
    // R4, R8: drain in order
    for (int i = 0; i < 4; i++) begin
      pop1();
      chk("R4", "order", rx_data, 32'hA000 + 32'(i));
      chk("R8", "overflow cleared", 32'(rx_ovf), 0);
    end
    chk("R8", "empty after last", 32'(rx_empty), 1);
    // R9: empty read
    pop1();
    chk("R9", "empty read data", rx_data, 0);
    chk("R9", "empty read level", 32'(rx_level), 0);

    // R2, R3: depth selection
    cfg1(1, 8);  chk("R2", "depth w8", 32'(rx_depth), 32);
    cfg1(1, 12); chk("R2", "depth w12", 32'(rx_depth), 16);
    cfg1(1, 20); chk("R2", "depth w20", 32'(rx_depth), 8);
    cfg1(1, 40); chk("R3", "rejected width keeps depth", 32'(rx_depth), 8);
    cfg1(0, 50); chk("R3", "mode loads with rejected width", 32'(rx_depth), 4);
    cfg1(1, 63); chk("R3", "stored width still 20", 32'(rx_depth), 8);

    // R11: push and pop together at depth
    for (int i = 0; i < 8; i++) push1(32'hB000 + 32'(i));
    cyc(1, 32'hBEEF, 1, 0, 0, 0, 0);
    chk("R11", "level stays", 32'(rx_level), 8);
    chk("R11", "oldest out", rx_data, 32'hB000);
    chk("R11", "no overflow", 32'(rx_ovf), 0);

    // R10: flush with a push and a pop
    cyc(1, 32'h1234, 1, 1, 0, 0, 0);
    chk("R10", "level", 32'(rx_level), 0);
    chk("R10", "empty", 32'(rx_empty), 1);
    chk("R10", "full", 32'(rx_full), 0);
    chk("R10", "rd_valid", 32'(rx_rv), 0);

    // Shrink depth while occupied
    cfg1(1, 4);
    for (int i = 0; i < 20; i++) push1(32'(i));
    cfg1(1, 30);
    chk("R5", "full above shrunk depth", 32'(rx_full), 1);

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      bit ps = ($urandom % 100) < 55;
      bit pp = ($urandom % 100) < 45;
      bit fl = ($urandom % 200) == 0;
      bit we = ($urandom % 64) == 0;
      cyc(ps, $urandom, pp, fl, we, 1'($urandom), int'($urandom % 64));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule